// File: doc/BRIEF.md
# Row-Sequenced Double-Sampling Pixel Readout

This block drives a pixel matrix one row at a time and turns the raw column samples of each row into a stream of zero-suppressed hits. For the active row it raises a one-hot select line and waits a settle time. It then captures every column's digitised current, which holds signal plus pedestal. Next it pulses that row's clear line to empty the collected charge and captures every column again, this time pedestal only. Finally it drops the select line. The two captures are subtracted column by column in parallel, and this removes the fixed per-pixel offset.

Each difference is compared against a programmable threshold. Columns that pass are tagged with their row and column and written into an intermediate hit buffer, which drains through a valid/ready stream. Rows advance from 0 to the last row and wrap back to 0, with a one-cycle marker at the start of row 0. A level start/stop input lets the readout go idle between bursts. If the hit buffer cannot absorb a row's hits, the sequencer holds off the next row instead of discarding data.

Top module: `cds_row_readout`

## Requirements
- R1: While reset is held, all select and clear lines, `frame_start`, `hit_valid` and `overflow` are low.
- R2: Rows are read in the order 0, 1, …, ROWS-1, 0, … and at most one select line is high at a time. `frame_start` is high for exactly the first select cycle of row 0 and low at every other time.
- R3: For each row the select line is high for t_settle+1 cycles of settling, then for at least t_sampa+1 cycles of first sampling. The row's clear line, and only that line, is then high for t_clear+1 cycles while select stays high. Select stays high for at least t_sampb+1 more cycles of second sampling and then falls.
- R4: A sampling phase accepts `samp_data` in the first cycle, once its count has expired, in which `samp_valid` is high, and then ends. `samp_valid` and `samp_data` have no effect at any other time.
- R5: The per-column value is first capture minus second capture, with each capture an unsigned 12-bit number. The result is saturated to the signed 12-bit range [-2048, 2047].
- R6: A column is a hit only when its signed value is strictly greater than the unsigned threshold `thr`. A value equal to the threshold is not a hit, and negative values never are.
- R7: Each hit word carries the row in bits [24:19], the column in bits [18:12] and the two's-complement value in bits [11:0]. The hits of one row leave in ascending column order, and rows leave in readout order.
- R8: No hit is ever lost. The next row's select does not rise until every hit of the previous row has entered the buffer. `overflow` is high exactly while a hit is waiting on a full buffer, and during that time all select lines are low.
- R9: When `run` is low, the row in progress completes, and no further row starts until `run` rises again. Readout then resumes with the following row.
- R10: While `hit_valid` is high and `hit_ready` is low, `hit_valid` stays high and `hit_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Level: high lets new rows start |
| thr | input | 12 | Unsigned hit threshold |
| t_settle | input | 8 | Select settle count |
| t_sampa | input | 8 | First sample phase count |
| t_clear | input | 8 | Clear pulse count |
| t_sampb | input | 8 | Second sample phase count |
| samp_valid | input | 1 | Column samples valid this cycle |
| samp_data | input | 1536 | 128 packed 12-bit column samples, column c at [12c+11:12c] |
| row_sel | output | 64 | One-hot row select lines |
| row_clr | output | 64 | Row clear lines |
| frame_start | output | 1 | Pulse on the first cycle of row 0 |
| hit_valid | output | 1 | Hit word available |
| hit_ready | input | 1 | Consumer accepts the hit word |
| hit_data | output | 25 | {row, column, value} |
| overflow | output | 1 | A hit is blocked by a full buffer |

## Verification
The bench goes after the values at the very edge of the hit decision: a difference equal to the threshold must stay silent, and a rail-to-rail capture must clamp. A design that compared unsigned or wrapped instead of clamping would emit hits for large negative differences. `samp_valid` is raised in settle, clear and early sample cycles with poisoned data, so a design that captured too early yields wrong or missing hits. A dense pattern that produces 127 hits per row is paired with a slow consumer. A sequencer that started the next row while hits were still waiting, or a buffer that dropped words, would show as a select line during `overflow` or as a missing word. The run is stopped in mid-row and resumed to confirm that the row counter neither skips nor repeats across the pause or across the wrap to row 0.

// File: rtl/cds_pkg.sv
package cds_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_SAMPA,
      ST_CLEAR,
      ST_SAMPB
   } seq_st_t;

   // clamp a (w+1)-bit signed difference into w bits
   function automatic logic [15:0] clamp_diff(input logic [16:0] raw, input int w);
      logic [15:0] res;
      logic        top, nxt;
      top = raw[w];
      nxt = raw[w-1];
      res = raw[15:0];
      if (!top && nxt) begin
         res = '0;
         for (int i = 0; i < 15; i++) if (i < w - 1) res[i] = 1'b1;
      end else if (top && !nxt) begin
         res = '0;
         for (int i = 0; i < 16; i++) if (i == w - 1) res[i] = 1'b1;
      end
      return res;
   endfunction

endpackage

// File: rtl/cds_row_seq.sv
module cds_row_seq
   import cds_pkg::*;
#(
   parameter int ROWS = 64,
   parameter int CW   = 8,
   localparam int RW  = $clog2(ROWS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            busy,
   input  logic            samp_valid,
   input  logic [CW-1:0]   t_settle,
   input  logic [CW-1:0]   t_sampa,
   input  logic [CW-1:0]   t_clear,
   input  logic [CW-1:0]   t_sampb,
   output logic [ROWS-1:0] row_sel,
   output logic [ROWS-1:0] row_clr,
   output logic            frame_start,
   output logic            cap_a,
   output logic            cap_b,
   output logic [RW-1:0]   row_idx
);

   seq_st_t       st;
   logic [CW-1:0] cnt;
   logic [RW-1:0] row;
   logic          fs_q;

   assign cap_a       = (st == ST_SAMPA) && (cnt == '0) && samp_valid;
   assign cap_b       = (st == ST_SAMPB) && (cnt == '0) && samp_valid;
   assign row_idx     = row;
   assign frame_start = fs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cnt  <= '0;
         row  <= '0;
         fs_q <= 1'b0;
      end else begin
         fs_q <= 1'b0;
         unique case (st)
            ST_IDLE: if (run && !busy) begin
               st   <= ST_SETTLE;
               cnt  <= t_settle;
               fs_q <= (row == '0);
            end
            ST_SETTLE: if (cnt == '0) begin
               st  <= ST_SAMPA;
               cnt <= t_sampa;
            end else cnt <= cnt - 1'b1;
            ST_SAMPA: if (cnt != '0) cnt <= cnt - 1'b1;
               else if (samp_valid) begin
                  st  <= ST_CLEAR;
                  cnt <= t_clear;
               end
            ST_CLEAR: if (cnt == '0) begin
               st  <= ST_SAMPB;
               cnt <= t_sampb;
            end else cnt <= cnt - 1'b1;
            ST_SAMPB: if (cnt != '0) cnt <= cnt - 1'b1;
               else if (samp_valid) begin
                  st  <= ST_IDLE;
                  row <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
               end
            default: st <= ST_IDLE;
         endcase
      end
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_line
      assign row_sel[r] = (st != ST_IDLE) && (row == RW'(r));
      assign row_clr[r] = (st == ST_CLEAR) && (row == RW'(r));
   end

   p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_sel));

   p_clr_in_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|row_clr) |-> (row_clr == row_sel));

   p_hold_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !run) |=> (st == ST_IDLE));

endmodule

// File: rtl/cds_hit_find.sv
module cds_hit_find
   import cds_pkg::*;
#(
   parameter int  ROWS     = 64,
   parameter int  COLS     = 128,
   parameter int  SW       = 12,
   parameter bit  SATURATE = 1'b1,
   localparam int RW       = $clog2(ROWS),
   localparam int CLW      = $clog2(COLS),
   localparam int HW       = RW + CLW + SW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [COLS*SW-1:0] samp_data,
   input  logic             cap_a,
   input  logic             cap_b,
   input  logic [SW-1:0]    thr,
   input  logic [RW-1:0]    row_idx,
   input  logic             buf_full,
   output logic             push,
   output logic [HW-1:0]    push_word,
   output logic             busy,
   output logic             overflow
);

   logic [SW-1:0]  a_q [COLS];
   logic [SW-1:0]  d_q [COLS];
   logic [COLS-1:0] mask, new_mask;
   logic [RW-1:0]  row_q;
   logic [CLW-1:0] pick;

   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [SW:0]   raw;
      logic [SW-1:0] dv;
      assign raw = {1'b0, a_q[c]} - {1'b0, samp_data[c*SW +: SW]};
      if (SATURATE) begin : g_sat
         logic [15:0] cl;
         assign cl = clamp_diff(17'(raw), SW);
         assign dv = cl[SW-1:0];
      end else begin : g_wrap
         assign dv = raw[SW-1:0];
      end
      assign new_mask[c] = $signed({dv[SW-1], dv}) > $signed({1'b0, thr});
      always_ff @(posedge clk) begin
         if (cap_a) a_q[c] <= samp_data[c*SW +: SW];
         if (cap_b) d_q[c] <= dv;
      end
   end

   always_comb begin
      pick = '0;
      for (int c = COLS - 1; c >= 0; c--) if (mask[c]) pick = CLW'(c);
   end

   assign busy      = |mask;
   assign push      = busy && !buf_full;
   assign overflow  = busy && buf_full;
   assign push_word = {row_q, pick, d_q[pick]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask  <= '0;
         row_q <= '0;
      end else if (cap_b) begin
         mask  <= new_mask;
         row_q <= row_idx;
      end else if (push) begin
         mask[pick] <= 1'b0;
      end
   end

   p_capb_drained_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_b |-> !busy);

   p_push_ascending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && $past(push) && !$past(cap_b) && $past(rst_n)) |-> (pick > $past(pick)));

endmodule

// File: rtl/cds_hit_fifo.sv
module cds_hit_fifo #(
   parameter int  W     = 25,
   parameter int  DEPTH = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic         full,
   output logic         rd_valid,
   input  logic         rd_ready,
   output logic [W-1:0] rd_data
);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("hit buffer depth must be a power of two, at least 2");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;
   logic         do_wr, do_rd;

   assign full     = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign rd_valid = (wp != rp);
   assign rd_data  = mem[rp[AW-1:0]];
   assign do_wr    = wr_en && !full;
   assign do_rd    = rd_valid && rd_ready;

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (do_wr) wp <= wp + 1'b1;
         if (do_rd) rp <= rp + 1'b1;
      end
   end

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !full);

   p_hold_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

// File: rtl/cds_row_readout.sv
module cds_row_readout #(
   parameter int ROWS       = 64,
   parameter int COLS       = 128,
   parameter int SW         = 12,
   parameter int CW         = 8,
   parameter int FIFO_DEPTH = 16,
   parameter bit SATURATE   = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run,
   input  logic [SW-1:0]          thr,
   input  logic [CW-1:0]          t_settle,
   input  logic [CW-1:0]          t_sampa,
   input  logic [CW-1:0]          t_clear,
   input  logic [CW-1:0]          t_sampb,
   input  logic                   samp_valid,
   input  logic [COLS*SW-1:0]     samp_data,
   output logic [ROWS-1:0]        row_sel,
   output logic [ROWS-1:0]        row_clr,
   output logic                   frame_start,
   output logic                   hit_valid,
   input  logic                   hit_ready,
   output logic [$clog2(ROWS)+$clog2(COLS)+SW-1:0] hit_data,
   output logic                   overflow
);

   localparam int RW  = $clog2(ROWS);
   localparam int CLW = $clog2(COLS);
   localparam int HW  = RW + CLW + SW;

   if (ROWS < 2 || COLS < 2 || SW < 2 || SW > 16 || CW < 1) begin : g_bad_cfg
      $error("unsupported row, column, sample or count width");
   end

   logic          busy, cap_a, cap_b, push, buf_full;
   logic [RW-1:0] row_idx;
   logic [HW-1:0] push_word;

   cds_row_seq #(.ROWS(ROWS), .CW(CW)) u_seq (
      .clk, .rst_n, .run, .busy, .samp_valid,
      .t_settle, .t_sampa, .t_clear, .t_sampb,
      .row_sel, .row_clr, .frame_start,
      .cap_a, .cap_b, .row_idx
   );

   cds_hit_find #(.ROWS(ROWS), .COLS(COLS), .SW(SW), .SATURATE(SATURATE)) u_find (
      .clk, .rst_n, .samp_data, .cap_a, .cap_b, .thr, .row_idx,
      .buf_full, .push, .push_word, .busy, .overflow
   );

   cds_hit_fifo #(.W(HW), .DEPTH(FIFO_DEPTH)) u_buf (
      .clk, .rst_n,
      .wr_en(push), .wr_data(push_word), .full(buf_full),
      .rd_valid(hit_valid), .rd_ready(hit_ready), .rd_data(hit_data)
   );

   p_start_after_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|row_sel) |-> !$past(busy));

   p_ovf_rows_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> (row_sel == '0));

endmodule

// File: tb/cds_row_readout_test.sv
module cds_row_readout_test;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run = 1'b0;
   logic [11:0]   thr = '0;
   logic [7:0]    t_settle = '0, t_sampa = '0, t_clear = '0, t_sampb = '0;
   logic          samp_valid = 1'b0;
   logic [1535:0] samp_data = '0;
   logic [63:0]   row_sel, row_clr;
   logic          frame_start, hit_valid, overflow;
   logic          hit_ready = 1'b0;
   logic [24:0]   hit_data;

   always #2 clk = ~clk;

   cds_row_readout uut (
      .clk, .rst_n, .run, .thr, .t_settle, .t_sampa, .t_clear, .t_sampb,
      .samp_valid, .samp_data, .row_sel, .row_clr, .frame_start,
      .hit_valid, .hit_ready, .hit_data, .overflow
   );

   int checks = 0, fails = 0, cyc = 0;
   int mode = 0, wext = 0, rmode = 0, thr_i = 0;
   bit gmode = 0;
   int ts = 0, ta = 0, tc = 0, tb = 0;
   logic [24:0] exp_q[$];

   bit in_row = 0;
   int phase = 0, n_pre = 0, n_clr = 0, n_post = 0, cur_idx = 0;
   int exp_row = 0, rows_done = 0, frames = 0;
   bit seen_ovf = 0, prev_v = 0, prev_r = 0;
   logic [24:0] prev_d = '0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int val(input int row, input int col, input bit second);
      int a, b;
      case (mode)
         0: begin
            b = 200;
            if ((col * 7 + row) % 13 == 0) a = 251 + (col % 40);
            else if (col == 5)                  a = 250;
            else if (col == 9)                  a = 150;
            else if (col == 0 && row % 2 == 0)  a = 260;
            else if (col == 127 && row % 3 == 0) a = 280;
            else                                a = 200 + col % 9;
         end
         1: begin a = 1000 + col; b = 1000; end
         default: case (col % 4)
            0: begin a = 4095; b = 0;    end
            1: begin a = 0;    b = 4095; end
            2: begin a = 2100; b = 100;  end
            default: begin a = 2101; b = 100; end
         endcase
      endcase
      return second ? b : a;
   endfunction

   function automatic logic [1535:0] bus_for(input int row, input bit second);
      logic [1535:0] v;
      for (int c = 0; c < 128; c++) v[c*12 +: 12] = 12'(val(row, c, second));
      return v;
   endfunction

   task automatic push_expected(input int row);
      for (int c = 0; c < 128; c++) begin
         int d;
         d = val(row, c, 0) - val(row, c, 1);
         if (d > 2047)  d = 2047;
         if (d < -2048) d = -2048;
         if (d > thr_i) exp_q.push_back({6'(row), 7'(c), 12'(d)});
      end
   endtask

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      if (rst_n) begin
         int idx, k1, k2;
         bit sel_any;
         sel_any = |row_sel;
         idx = 0;
         for (int r = 0; r < 64; r++) if (row_sel[r]) idx = r;
         chk($countones(row_sel) <= 1, "R2 one-hot select", $countones(row_sel), 1);
         if (sel_any) begin
            if (!in_row) begin
               in_row = 1; phase = 0; n_pre = 0; n_clr = 0; n_post = 0; cur_idx = idx;
               chk(idx == exp_row, "R2 row order", idx, exp_row);
               chk(frame_start == (exp_row == 0), "R2 frame marker at row start",
                   frame_start, exp_row == 0);
               if (frame_start) frames++;
            end else begin
               chk(!frame_start, "R2 frame marker width", frame_start, 0);
               chk(idx == cur_idx, "R3 select steady in row", idx, cur_idx);
            end
            if (|row_clr) begin
               phase = 1; n_clr++;
               chk(row_clr == row_sel, "R3 clear on selected row", int'(row_clr != 0), 1);
               chk(n_post == 0, "R3 single clear pulse", n_post, 0);
            end else if (phase == 0) n_pre++;
            else begin phase = 2; n_post++; end
         end else begin
            chk(row_clr == '0 && !frame_start, "R3 lines idle between rows", int'(row_clr != 0), 0);
            if (in_row) begin
               in_row = 0;
               chk(n_pre == ts + ta + 2 + wext, "R3/R4 select before clear", n_pre, ts + ta + 2 + wext);
               chk(n_clr == tc + 1, "R3 clear length", n_clr, tc + 1);
               chk(n_post == tb + 1 + wext, "R3/R4 select after clear", n_post, tb + 1 + wext);
               push_expected(cur_idx);
               exp_row = (exp_row + 1) % 64;
               rows_done++;
            end
         end
         if (overflow) begin
            seen_ovf = 1;
            chk(row_sel == '0 && hit_valid, "R8 overflow only with rows idle and buffer full",
                int'(row_sel != 0), 0);
         end

         // sample stimulus for the coming edge
         k1 = ts + ta + 2;
         k2 = tb + 1;
         if (!in_row) begin
            samp_valid = gmode; samp_data = '0;
         end else if (phase == 0) begin
            samp_valid = (n_pre >= k1 + wext) || (gmode && n_pre < k1 && n_pre % 2 == 1);
            samp_data  = (n_pre >= k1 || !gmode) ? bus_for(cur_idx, 0) : '0;
         end else if (phase == 1) begin
            samp_valid = gmode; samp_data = '1;
         end else begin
            samp_valid = (n_post >= k2 + wext) || (gmode && n_post < k2 && n_post % 2 == 1);
            samp_data  = (n_post >= k2 || !gmode) ? bus_for(cur_idx, 1) : '1;
         end

         if (prev_v && !prev_r)
            chk(hit_valid && hit_data == prev_d, "R10 held output", int'(hit_data), int'(prev_d));
         case (rmode)
            0: hit_ready = 1'b1;
            1: hit_ready = (cyc % 3 != 0);
            default: hit_ready = (cyc % 7 == 0);
         endcase
         if (hit_valid && hit_ready) begin
            if (exp_q.size() == 0) chk(0, "R7 unexpected hit", int'(hit_data), 0);
            else begin
               logic [24:0] e;
               e = exp_q.pop_front();
               chk(hit_data == e, "R5/R6/R7 hit word", int'(hit_data), int'(e));
            end
         end
         prev_v = hit_valid; prev_r = hit_ready; prev_d = hit_data;
      end
   end

   task automatic config_run(input int s, input int a, input int c, input int b,
                             input int th, input int m, input int w, input bit g, input int rm);
      ts = s; ta = a; tc = c; tb = b; thr_i = th; mode = m; wext = w; gmode = g; rmode = rm;
      t_settle = 8'(s); t_sampa = 8'(a); t_clear = 8'(c); t_sampb = 8'(b); thr = 12'(th);
   endtask

   task automatic run_rows(input int n);
      int target;
      @(negedge clk);
      target = rows_done + n;
      run = 1'b1;
      wait (rows_done >= target);
      run = 1'b0;
      repeat (30) begin
         @(negedge clk);
         chk(row_sel == '0, "R9 no row while stopped", int'(row_sel != 0), 0);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(row_sel == '0 && row_clr == '0, "R1 lines low in reset", int'(row_sel != 0), 0);
      chk(!hit_valid && !frame_start && !overflow, "R1 flags low in reset", int'(hit_valid), 0);
      rst_n = 1'b1;

      // sparse pattern, wraps past row 63 and back to row 0
      config_run(1, 2, 1, 1, 50, 0, 0, 0, 0);
      run_rows(70);
      // clamped values with poisoned early strobes, resumes from row 6
      config_run(0, 0, 0, 0, 2000, 2, 3, 1, 1);
      run_rows(5);
      // dense rows with a slow consumer, forcing stalls
      config_run(2, 0, 3, 0, 0, 1, 0, 1, 2);
      run_rows(3);

      wait (exp_q.size() == 0 && !hit_valid);
      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0 && !hit_valid, "R8 all hits delivered", exp_q.size(), 0);
      chk(seen_ovf, "R8 overflow seen under stall", seen_ovf, 1);
      chk(frames == 2, "R2 frame marker count", frames, 2);
      chk(exp_row == 14, "R9 row count across pauses", exp_row, 14);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R8/R9: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule